// File: doc/BRIEF.md
# Power-Fail SRAM Chip-Enable Gate

This block sits between a host's active-low chip enable and an external battery-backed SRAM. While the supply is good, the enable passes straight through. When a digital power-fail indication rises, the block shuts the enable. The one exception is an SRAM access that is already under way: it may run to its end, but only for a bounded number of timer ticks. After the supply returns, the enable is held off for a long recovery interval before pass-through resumes. The same logic produces a write-protect flag for on-chip clock and storage registers. That flag is raised whenever the enable path is not in pass-through, and in any cycle in which power-fail is asserted.

After reset the block is isolated. The enable stays inactive until valid power is first seen, and that first power-up also runs the full recovery interval. Timing is counted in ticks of an external strobe, normally one per microsecond. The grace and recovery lengths are parameters in ticks. Their defaults are 30 and 200 000, which give 30 µs and 200 ms at a 1 µs tick.

Top module: `sram_pf_gate`

## Requirements
- R1: Reset (rst_n low at a clock edge) puts the block in the isolated state: ce_out_n = 1 and wr_protect = 1. Both stay there while pwr_fail = 1.
- R2: In pass-through with pwr_fail = 0, ce_out_n equals ce_in_n in the same cycle, with no register in the path, and wr_protect = 0.
- R3: Pass-through ends in the first cycle pwr_fail = 1. If ce_in_n was high in that cycle or the one before, no access is in flight, and ce_out_n = 1 from that cycle on, whatever ce_in_n does.
- R4: If ce_in_n was low both in the cycle before and in the first cycle with pwr_fail = 1, an access is in flight. ce_out_n follows ce_in_n until ce_in_n rises or the grace timeout expires.
- R5: The grace timer starts at GRACE_TICKS on entry. It counts down on each tick sampled at a clock edge after entry. ce_out_n is forced to 1 in the cycle after the edge that brings it to zero.
- R6: Once ce_in_n has risen during the grace window, a later falling ce_in_n does not reach ce_out_n. No new access starts.
- R7: When pwr_fail falls, ce_out_n and wr_protect stay 1 until RECOVER_TICKS ticks have been sampled. Pass-through resumes one cycle later. If pwr_fail rises again during recovery, recovery aborts, and the full interval is needed once power returns.
- R8: wr_protect is 1 in every cycle with pwr_fail = 1 and in every state other than pass-through.
- R9: Leaving isolation on the first pwr_fail = 0 always runs the full recovery interval of R7 before any pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe, one per time unit |
| pwr_fail | input | 1 | 1 = supply below detect threshold (synchronous) |
| ce_in_n | input | 1 | Active-low SRAM chip enable from the host |
| ce_out_n | output | 1 | Gated active-low chip enable to the SRAM |
| wr_protect | output | 1 | 1 = on-chip register writes blocked |

## Verification
Some results are combinational and are due in the same cycle as their cause:
- ce_out_n in pass-through, the first power-fail cycle and the grace window;
- wr_protect on pwr_fail.

State changes show one cycle after the edge that samples their cause:
- entering block or recovery;
- grace expiry, one cycle after the edge that counts the last tick;
- the return to pass-through, one cycle after the edge that finds the recovery count at zero.

The bench updates its model of state and tick counts at each rising edge from the inputs sampled there, and drives new inputs 1 ns later. It compares both outputs 2 ns after that, so each comparison sees the state after the edge and the inputs of the current cycle.

// File: rtl/pg_pkg.sv
// Package: shared state encoding of the power-fail chip-enable gate.
package pg_pkg;
    typedef enum logic [2:0] {
        S_ISO   = 3'd0,  // isolated since reset, no valid power seen yet
        S_PASS  = 3'd1,  // power valid, enable passes through
        S_GRACE = 3'd2,  // power failed, in-flight access allowed to end
        S_BLOCK = 3'd3,  // power failed, enable forced inactive
        S_HOLD  = 3'd4   // power back, recovery hold-off running
    } pg_state_e;
endpackage

// File: rtl/pg_tick_timer.sv
// Module: pg_tick_timer
// Down-counter of tick strobes. A load sets the count; every later tick
// decrements it until it reaches zero, where it rests.
// Assumes: tick is a single-cycle strobe synchronous to clk.
module pg_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Purpose: load has priority; otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R5: an expired count never wraps back without a load.
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/pg_mode_fsm.sv
// Module: pg_mode_fsm
// Mode sequencer: isolation, pass-through, grace, block and recovery.
// It picks the timer load value on each entry to grace or recovery.
// Assumes: pwr_fail is already synchronous to clk.
module pg_mode_fsm
    import pg_pkg::*;
#(
    parameter int CW            = 8,
    parameter int GRACE_TICKS   = 30,
    parameter int RECOVER_TICKS = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          ce_in_n,
    input  logic          timer_zero,
    output pg_state_e     state,
    output logic          ce_prev_n,
    output logic          timer_load,
    output logic [CW-1:0] timer_val
);
    pg_state_e state_q, state_d;
    logic      ce_q_n;

    // Purpose: next-state and timer-load decision.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = CW'(RECOVER_TICKS);
        unique case (state_q)
            S_ISO: if (!pwr_fail) begin
                state_d    = S_HOLD;
                timer_load = 1'b1;
            end
            S_PASS: if (pwr_fail) begin
                if (!ce_in_n && !ce_q_n) begin
                    state_d    = S_GRACE;
                    timer_load = 1'b1;
                    timer_val  = CW'(GRACE_TICKS);
                end else begin
                    state_d = S_BLOCK;
                end
            end
            S_GRACE: if (ce_in_n || timer_zero) state_d = S_BLOCK;
            S_BLOCK: if (!pwr_fail) begin
                state_d    = S_HOLD;
                timer_load = 1'b1;
            end
            S_HOLD: begin
                if (pwr_fail)        state_d = S_BLOCK;
                else if (timer_zero) state_d = S_PASS;
            end
            default: state_d = S_ISO;
        endcase
    end

    // Purpose: state register and one-cycle history of the input enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ISO;
            ce_q_n  <= 1'b1;
        end else begin
            state_q <= state_d;
            ce_q_n  <= ce_in_n;
        end
    end

    assign state     = state_q;
    assign ce_prev_n = ce_q_n;

    // R7: pass-through is entered only from recovery with the count at zero.
    p_pass_from_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == S_PASS && state_q != S_PASS) |-> (state_q == S_HOLD && timer_zero && !pwr_fail));
    // R9: isolation is left only towards recovery.
    p_iso_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISO) |=> (state_q == S_ISO || state_q == S_HOLD));
endmodule

// File: rtl/pg_ce_mux.sv
// Module: pg_ce_mux
// Output gating: pass-through, in-flight honouring, forced-off enable and
// write-protect, all combinational from state and current inputs.
// Assumes: ce_prev_n is ce_in_n delayed by one clock.
module pg_ce_mux
    import pg_pkg::*;
(
    input  pg_state_e state,
    input  logic      pwr_fail,
    input  logic      ce_in_n,
    input  logic      ce_prev_n,
    input  logic      timer_zero,
    output logic      ce_out_n,
    output logic      wr_protect
);
    // Purpose: choose the gated enable for the current state.
    always_comb begin
        unique case (state)
            S_PASS:  ce_out_n = pwr_fail ? (ce_in_n | ce_prev_n) : ce_in_n;
            S_GRACE: ce_out_n = ce_in_n | timer_zero;
            default: ce_out_n = 1'b1;
        endcase
    end

    // Purpose: block register writes outside clean pass-through.
    assign wr_protect = (state != S_PASS) | pwr_fail;
endmodule

// File: rtl/sram_pf_gate.sv
// Module: sram_pf_gate (top)
// Gates an external battery-backed SRAM chip enable on power failure,
// honours a bounded in-flight access, holds off after power returns and
// drives a write-protect flag for on-chip registers.
// Assumes: pwr_fail and ce_in_n synchronous to clk; tick a 1-cycle strobe.
module sram_pf_gate
    import pg_pkg::*;
#(
    parameter int GRACE_TICKS   = 30,
    parameter int RECOVER_TICKS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_fail,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic wr_protect
);
    localparam int MAX_TICKS = (GRACE_TICKS > RECOVER_TICKS) ? GRACE_TICKS : RECOVER_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1) < 1 ? 1 : $clog2(MAX_TICKS + 1);

    pg_state_e     state;
    logic          ce_prev_n;
    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          timer_zero;

    pg_mode_fsm #(
        .CW(CW), .GRACE_TICKS(GRACE_TICKS), .RECOVER_TICKS(RECOVER_TICKS)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ce_in_n(ce_in_n),
        .timer_zero(timer_zero), .state(state), .ce_prev_n(ce_prev_n),
        .timer_load(timer_load), .timer_val(timer_val)
    );

    pg_tick_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
        .tick(tick), .zero(timer_zero)
    );

    pg_ce_mux mux_i (
        .state(state), .pwr_fail(pwr_fail), .ce_in_n(ce_in_n),
        .ce_prev_n(ce_prev_n), .timer_zero(timer_zero),
        .ce_out_n(ce_out_n), .wr_protect(wr_protect)
    );

    // R1: isolation keeps everything shut while power is bad.
    p_iso_shut_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISO && pwr_fail) |=> (ce_out_n && wr_protect));
    // R8: power-fail always blocks register writes.
    p_wp_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> wr_protect);
    // R3: the block state never lets the enable through.
    p_block_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BLOCK) |-> ce_out_n);
    // R6: a rise of the input during grace ends the window for good.
    p_no_refall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GRACE && ce_in_n) |=> ce_out_n);
    // R2: clean pass-through is transparent.
    p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS && !pwr_fail) |-> (ce_out_n == ce_in_n && !wr_protect));
endmodule

// File: tb/sram_pf_gate_tb_top.sv
// Bench: cycle model of the requirements, random plus directed stimulus.
module sram_pf_gate_tb_top;
    localparam int GR  = 5;
    localparam int REC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pwr_fail = 1'b1;
    logic ce_in_n = 1'b1;
    logic ce_out_n, wr_protect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: 0 iso, 1 pass, 2 grace, 3 block, 4 hold
    int  m_st = 0;
    int  m_cnt = 0;
    logic m_ceq = 1'b1;
    bit  first_up = 1'b0;

    always #5 clk = ~clk;

    sram_pf_gate #(.GRACE_TICKS(GR), .RECOVER_TICKS(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
        .ce_in_n(ce_in_n), .ce_out_n(ce_out_n), .wr_protect(wr_protect)
    );

    // advance the model with the inputs sampled at this edge
    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ceq = 1'b1; first_up = 1'b0;
            return;
        end
        case (m_st)
            0: if (!pwr_fail) begin m_st = 4; m_cnt = REC; first_up = 1'b1; end
            1: if (pwr_fail) begin
                   if (!ce_in_n && !m_ceq) begin m_st = 2; m_cnt = GR; end
                   else m_st = 3;
               end
            2: if (ce_in_n || m_cnt == 0) m_st = 3;
               else if (tick) m_cnt--;
            3: if (!pwr_fail) begin m_st = 4; m_cnt = REC; first_up = 1'b0; end
            4: if (pwr_fail) begin m_st = 3; first_up = 1'b0; end
               else if (m_cnt == 0) begin m_st = 1; first_up = 1'b0; end
               else if (tick) m_cnt--;
            default: m_st = 0;
        endcase
        m_ceq = ce_in_n;
    endtask

    function automatic logic exp_ce();
        case (m_st)
            1: return pwr_fail ? (ce_in_n | m_ceq) : ce_in_n;
            2: return ce_in_n | (m_cnt == 0);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string tag_of();
        case (m_st)
            0: return "R1";
            1: return pwr_fail ? (m_ceq ? "R3" : "R4") : "R2";
            2: return (m_cnt == 0) ? "R5" : (ce_in_n ? "R6" : "R4");
            3: return "R3";
            default: return first_up ? "R9" : "R7";
        endcase
    endfunction

    task automatic check_outputs();
        logic e_ce, e_wp;
        string t;
        e_ce = exp_ce();
        e_wp = (m_st != 1) || pwr_fail;
        t = tag_of();
        checks++;
        if (ce_out_n !== e_ce) begin
            errors++;
            $display("FAIL %s ce_out_n actual %b expected %b at %0t", t, ce_out_n, e_ce, $time);
        end
        checks++;
        if (wr_protect !== e_wp) begin
            errors++;
            $display("FAIL R8 wr_protect actual %b expected %b (%s) at %0t", wr_protect, e_wp, t, $time);
        end
    endtask

    // one clock: model update at the edge, new inputs, then compare
    task automatic cyc(input logic pf, input logic ce, input logic tk);
        @(posedge clk);
        model_step();
        #1;
        pwr_fail = pf; ce_in_n = ce; tick = tk;
        #2;
        if (rst_n) check_outputs();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // reset, then R1 check of outputs
        repeat (3) cyc(1'b1, 1'b1, 1'b0);
        @(posedge clk); model_step(); #1; rst_n = 1'b1; #2;
        checks++;
        if (ce_out_n !== 1'b1 || wr_protect !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b%b expected 11", ce_out_n, wr_protect);
        end
        // R1: stays isolated with ce low and power bad
        repeat (6) cyc(1'b1, 1'b0, 1'b1);
        // R9: first power-up, full recovery, ticks every cycle
        repeat (REC + 4) cyc(1'b0, 1'b0, 1'b1);
        // R2: pass-through toggles
        for (int i = 0; i < 8; i++) cyc(1'b0, i[0], 1'b0);
        // R4/R5: access in flight, hold ce low past the grace timeout
        repeat (2) cyc(1'b0, 1'b0, 1'b0);
        repeat (GR * 3 + 4) cyc(1'b1, 1'b0, 1'b1);
        // R7: recovery aborted by a new fail, then completed
        repeat (5) cyc(1'b0, 1'b1, 1'b1);
        repeat (3) cyc(1'b1, 1'b1, 1'b1);
        repeat (REC + 4) cyc(1'b0, 1'b1, 1'b1);
        // R6: in-flight access ends, input falls again inside the window
        repeat (2) cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        repeat (4) cyc(1'b1, 1'b0, 1'b0);
        // R3: fail with ce just falling (no access in flight)
        repeat (REC + 4) cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        repeat (4) cyc(1'b1, 1'b0, 1'b0);
        // random phases
        begin
            logic pf, ce;
            int seg;
            pf = 1'b0; ce = 1'b1; seg = 0;
            for (int i = 0; i < 20000; i++) begin
                if (seg == 0) begin
                    pf = ~pf;
                    seg = pf ? 3 + int'($urandom % 20) : 5 + int'($urandom % 60);
                end
                seg--;
                if ($urandom % 4 == 0) ce = ~ce;
                cyc(pf, ce, ($urandom % 3) == 0);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule